// File: doc/BRIEF.md
# Reversible Stage Power-Clock Sequencer

This controller produces the phase schedule for a chain of logic stages that are powered by paired ramped supply rails. Each stage has one rising rail and one complementary falling rail. A single operation has two halves. In the compute half, the stages are energised strictly one after another. Each stage that has finished rising keeps its level while every later stage rises. A one-cycle top point follows, in which all stages hold. In the uncompute half, the stages are released in the opposite order, last stage first. A new operation can begin only after every stage has relaxed again.

For each stage, the block outputs a two-bit phase code. It also outputs one shared digital ramp level that belongs to whichever stage is currently ramping. The complementary rail level is given as the full-scale value minus that ramp level. An analog driver outside the block turns these codes and levels into real rail voltages. A static mode bypasses the sequencing. In static mode, every stage is held energised, with the rising rails at full scale and the falling rails at zero, exactly as a plain fixed supply would be.

Top module: `power_clock_sequencer`

## Requirements
- R1: After reset, every stage phase is RELAXED (code 2'b00), `pos_level` is 0, `neg_level` is RAMP_LEN, `ready` is 1, `done` is 0, and the block is in sequenced (non-static) mode.
- R2: Phase codes are RELAXED=2'b00, RAMP_UP=2'b01, HOLD=2'b10 and RAMP_DOWN=2'b11. Stage k occupies bits [2k+1:2k] of `phase`, with stage 0 energised first. After an accepted `start`, stage 0 ramps up in the next cycle. Each stage spends RAMP_LEN cycles in RAMP_UP, with `pos_level` stepping 1, 2, …, RAMP_LEN. The next stage begins rising in the cycle after that.
- R3: While a stage ramps up, every lower-numbered stage is in HOLD and every higher-numbered stage is RELAXED.
- R4: One cycle after the last stage reaches full level, all stages show HOLD, `pos_level` is RAMP_LEN, and `done` is high for exactly that one cycle.
- R5: After the top cycle, the stages ramp down from the highest-numbered stage to stage 0. Each spends RAMP_LEN cycles in RAMP_DOWN with `pos_level` stepping RAMP_LEN-1 down to 0, while lower stages hold and higher stages are RELAXED. After stage 0 finishes, all stages are RELAXED.
- R6: In every cycle, `neg_level` equals RAMP_LEN minus `pos_level`.
- R7: `ready` is low from the first ramp cycle through the last release cycle. A `start` seen while `ready` is low is ignored, so one operation takes exactly 2·NSTAGE·RAMP_LEN+1 cycles with no overlap.
- R8: When static mode is active, every stage shows HOLD, `pos_level` is RAMP_LEN, `neg_level` is 0, and `start` is ignored.
- R9: `static_req` is sampled only while `ready` is high and takes effect in the next cycle. A value presented while an operation is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| static_req | input | 1 | Requested mode: 1 selects static rails, 0 selects sequencing |
| start | input | 1 | Begin one compute/uncompute operation |
| ready | output | 1 | High when no operation is running |
| done | output | 1 | One-cycle pulse when all stages hold at the top point |
| phase | output | 2*NSTAGE | Per-stage phase codes, two bits each |
| pos_level | output | clog2(RAMP_LEN+1) | Ramp level of the rising rail |
| neg_level | output | clog2(RAMP_LEN+1) | Complementary falling-rail level |

## Verification
The first pattern is a single isolated start pulse. It shows the forward order and hold behaviour apart from the reverse release, because every stage index is checked against a time-indexed reference. The second pattern repeats start pulses and toggles the mode during a running operation. It separates a correct no-overlap controller from one that restarts mid-cycle or switches mode early. A static-mode interval with start pulses shows that the bypass really ignores sequencing. The last pattern holds start high, so that back-to-back operations expose any off-by-one at the boundary between the release end and the next acceptance.

// File: rtl/power_clock_sequencer.sv
module power_clock_sequencer #(
  parameter int NSTAGE   = 11,
  parameter int RAMP_LEN = 4,
  localparam int LW = $clog2(RAMP_LEN + 1),
  localparam int SW = (NSTAGE > 1) ? $clog2(NSTAGE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                static_req,
  input  logic                start,
  output logic                ready,
  output logic                done,
  output logic [2*NSTAGE-1:0] phase,
  output logic [LW-1:0]       pos_level,
  output logic [LW-1:0]       neg_level
);

  typedef enum logic [1:0] {S_IDLE, S_UP, S_TOP, S_DOWN} state_t;

  localparam logic [LW-1:0] FULL = LW'(RAMP_LEN);
  localparam logic [SW-1:0] LAST = SW'(NSTAGE - 1);

  state_t          state;
  logic [SW-1:0]   stg;
  logic [LW-1:0]   cnt;
  logic            static_q;
  logic [NSTAGE-1:0] ramping;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      stg      <= '0;
      cnt      <= '0;
      static_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          static_q <= static_req;
          if (start && !static_q) begin
            state <= S_UP;
            stg   <= '0;
            cnt   <= LW'(1);
          end
        end
        S_UP: begin
          if (cnt == FULL) begin
            cnt <= LW'(1);
            if (stg == LAST) state <= S_TOP;
            else             stg   <= stg + SW'(1);
          end else begin
            cnt <= cnt + LW'(1);
          end
        end
        S_TOP: begin
          state <= S_DOWN;
          cnt   <= LW'(1);
        end
        default: begin
          if (cnt == FULL) begin
            cnt <= LW'(1);
            if (stg == '0) state <= S_IDLE;
            else           stg   <= stg - SW'(1);
          end else begin
            cnt <= cnt + LW'(1);
          end
        end
      endcase
    end
  end

  for (genvar gi = 0; gi < NSTAGE; gi++) begin : g_phase
    assign phase[2*gi +: 2] =
        (state == S_IDLE) ? (static_q ? 2'b10 : 2'b00) :
        (state == S_TOP)  ? 2'b10 :
        (SW'(gi) < stg)   ? 2'b10 :
        (SW'(gi) == stg)  ? ((state == S_UP) ? 2'b01 : 2'b11) :
                            2'b00;
    assign ramping[gi] = phase[2*gi];
  end

  assign ready     = (state == S_IDLE);
  assign done      = (state == S_TOP);
  assign pos_level = (state == S_UP)   ? cnt :
                     (state == S_DOWN) ? FULL - cnt :
                     ((state == S_TOP) || static_q) ? FULL : '0;
  assign neg_level = FULL - pos_level;

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  single_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ramping) <= 1);

  // R2
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_level <= FULL);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(static_q));

  // R7
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start && !static_q) |=> (!ready && !done));

  // R8
  static_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && static_q) |-> (pos_level == FULL));

endmodule

// File: tb/power_clock_sequencer_test.sv
module power_clock_sequencer_test;
  localparam int N  = 11;
  localparam int R  = 4;
  localparam int NR = N * R;
  localparam int LW = $clog2(R + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic static_req = 0;
  logic start = 0;
  logic ready, done;
  logic [2*N-1:0] phase;
  logic [LW-1:0] pos_level, neg_level;

  int total = 0;
  int bad = 0;

  bit m_busy = 0;
  int m_t = 0;
  bit m_st = 0;
  string scen = "R1 reset";

  always #2 clk = ~clk;

  power_clock_sequencer #(.NSTAGE(N), .RAMP_LEN(R)) uut (
    .clk(clk), .rst_n(rst_n), .static_req(static_req), .start(start),
    .ready(ready), .done(done), .phase(phase),
    .pos_level(pos_level), .neg_level(neg_level));

  function automatic int exp_code(int i);
    int s, u;
    if (!m_busy) return m_st ? 2 : 0;
    if (m_t < NR) begin
      s = m_t / R;
      return (i < s) ? 2 : (i == s) ? 1 : 0;
    end
    if (m_t == NR) return 2;
    u = m_t - NR - 1;
    s = N - 1 - u / R;
    return (i < s) ? 2 : (i == s) ? 3 : 0;
  endfunction

  function automatic int exp_pos();
    if (!m_busy) return m_st ? R : 0;
    if (m_t < NR) return m_t % R + 1;
    if (m_t == NR) return R;
    return R - ((m_t - NR - 1) % R + 1);
  endfunction

  function automatic string ptag();
    if (!m_busy) return m_st ? "R8" : "R1";
    if (m_t < R) return "R2";
    if (m_t < NR) return "R3";
    if (m_t == NR) return "R4";
    return "R5";
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] t=%0d actual=%0d expected=%0d", tag, scen, m_t, act, exp);
    end
  endtask

  task automatic cyc(bit st_v, bit md_v);
    @(negedge clk);
    for (int i = 0; i < N; i++) chk(ptag(), int'(phase[2*i +: 2]), exp_code(i));
    chk(ptag(), int'(pos_level), exp_pos());
    chk("R6", int'(neg_level), R - exp_pos());
    chk("R4", int'(done), (m_busy && m_t == NR) ? 1 : 0);
    chk("R7", int'(ready), m_busy ? 0 : 1);
    start = st_v;
    static_req = md_v;
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_st = 0;
    end else if (!m_busy) begin
      if (st_v && !m_st) begin m_busy = 1; m_t = 0; end
      m_st = md_v;
    end else if (m_t == 2 * NR) begin
      m_busy = 0;
    end else begin
      m_t++;
    end
  endtask

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(0, 0);
    cyc(0, 0);
    rst_n = 1;
    for (int k = 0; k < 3; k++) cyc(0, 0);
    scen = "R2 R3 R4 R5 single start";
    cyc(1, 0);
    for (int k = 0; k < 2 * NR + 4; k++) cyc(0, 0);
    scen = "R7 R9 start and mode toggled while busy";
    cyc(1, 0);
    for (int k = 0; k < 2 * NR + 3; k++) cyc(k % 7 == 0, k % 2 == 0);
    scen = "R8 static mode with start pulses";
    cyc(0, 1);
    for (int k = 0; k < 12; k++) cyc(k % 2 == 1, 1);
    scen = "R7 back-to-back start held high";
    cyc(0, 0);
    for (int k = 0; k < 4 * NR + 6; k++) cyc(1, 0);
    for (int k = 0; k < 3; k++) cyc(0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule